// File: doc/BRIEF.md
# Periodic Interval Timer with Programmable Limit

This block is a free-running interval timer that software controls through a small word-addressed register window. A prescaler divides the system clock into fixed 500 ns steps. Each step advances a 22-bit counter that sits in bits 30:9 of the count word, so bits 8:0 always read as zero. When the next step would bring the counter to the programmed limit, the counter returns to zero. At the same time a sticky "reached" flag sets and a level interrupt rises. The timer keeps running, so the interrupt comes back once per period.

Software acknowledges an expiry by reading the limit word, which clears both the flag and the interrupt. A new limit can be written in two ways. One write restarts the counter and the prescaler from zero. The other swaps the limit in while the count keeps running. A limit whose live bits are all zero stands for the largest limit.

Top module: `interval_timer`

## Requirements
- R1: After reset the limit word reads 0x7FFFFE00, the count word reads 0 and `irqOut` is low.
- R2: The counter advances by one step (a value of 0x200 in the count word) once every TICK_DIV clock cycles, and bits 8:0 of the count word always read zero.
- R3: On a step where the incremented count would equal or exceed the limit, the count becomes 0, the reached flag sets and `irqOut` rises. A limit of L steps therefore expires every L steps, with no end.
- R4: A read strobe at word offset 0 returns the limit with bit 31 zero. From the next cycle on it clears the reached flag and `irqOut`. If an expiry falls on the same edge, the expiry wins.
- R5: A write at word offset 0 stores `regWdata & 0x7FFFFE00` as the limit, restarts the count and the prescaler at zero and drops `irqOut`. The reached flag is left unchanged.
- R6: A write at word offset 2 stores the limit with the same masking, but the count and the prescaler phase carry on untouched.
- R7: A limit that masks to zero through either write offset is stored as 0x7FFFFE00.
- R8: The word at offset 1 reads as the reached flag in bit 31 and the count in bits 30:9. Reading it has no side effect.
- R9: The offset is taken from `regAddr[4:2]`, and `regAddr[1:0]` is ignored. Offsets 2 through 7 read as zero. Writes to offsets 1 and 3 through 7 change neither the limit nor the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Write strobe for the addressed word |
| regRd | input | 1 | Read strobe; enables the read side effect at offset 0 |
| regAddr | input | 5 | Byte address within the 0x20-byte window |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for the addressed word (combinational) |
| irqOut | output | 1 | Level interrupt, high after an expiry until acknowledged |

## Verification
The bench sets TICK_DIV to 3 instead of the production value 125, so one step takes three clocks. This brings whole expiry periods, and several of them back to back, within a few dozen cycles. With that setting the bench sweeps every limit from one to six steps, cycle by cycle. It predicts the count word and the interrupt arithmetically from the elapsed cycle count. It also places the acknowledge read on the exact edge of an expiry, and lowers the limit below the running count.

// File: rtl/interval_timer_pkg.sv
package interval_timer_pkg;

  // Word offsets decoded from the address; the bench and software rely on them.
  localparam logic [2:0] OFS_LIMIT_RESTART = 3'd0;
  localparam logic [2:0] OFS_COUNT         = 3'd1;
  localparam logic [2:0] OFS_LIMIT_KEEP    = 3'd2;

  // Strobes from control to datapath.
  typedef struct packed {
    logic cntClear;   // restart count and prescaler
    logic limitLoad;  // capture a new limit
  } ctlStrobes_t;

endpackage

// File: rtl/it_datapath.sv
module it_datapath
  import interval_timer_pkg::*;
#(
  parameter int STEP_W   = 22,
  parameter int TICK_DIV = 125
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [STEP_W-1:0] limitField,
  output logic [STEP_W-1:0] stepCount,
  output logic [STEP_W-1:0] limitSteps,
  output logic              wrapEvent
);

  localparam logic [STEP_W-1:0] MAX_STEPS = '1;

  logic          tick;
  logic [STEP_W:0] nextStep;

  // Prescaler: one tick every TICK_DIV clocks, phase restarted by cntClear.
  generate
    if (TICK_DIV <= 1) begin : g_noDiv
      assign tick = 1'b1;
    end else begin : g_div
      localparam int TICK_W = $clog2(TICK_DIV);
      logic [TICK_W-1:0] tickCnt;
      always_ff @(posedge clk) begin
        if (!rstN || ctl.cntClear) begin
          tickCnt <= '0;
        end else if (tickCnt == TICK_W'(TICK_DIV - 1)) begin
          tickCnt <= '0;
        end else begin
          tickCnt <= tickCnt + TICK_W'(1);
        end
      end
      assign tick = (tickCnt == TICK_W'(TICK_DIV - 1));
    end
  endgenerate

  assign nextStep  = {1'b0, stepCount} + {{STEP_W{1'b0}}, 1'b1};
  assign wrapEvent = tick && !ctl.cntClear && (nextStep >= {1'b0, limitSteps});

  // Counter
  always_ff @(posedge clk) begin
    if (!rstN || ctl.cntClear) begin
      stepCount <= '0;
    end else if (wrapEvent) begin
      stepCount <= '0;
    end else if (tick) begin
      stepCount <= nextStep[STEP_W-1:0];
    end
  end

  // Limit register, zero selects the maximum
  always_ff @(posedge clk) begin
    if (!rstN) begin
      limitSteps <= MAX_STEPS;
    end else if (ctl.limitLoad) begin
      limitSteps <= (limitField == '0) ? MAX_STEPS : limitField;
    end
  end

  a_r5_clear_zeroes: assert property (@(posedge clk) disable iff (!rstN)
    ctl.cntClear |=> (stepCount == '0));

  a_r7_zero_means_max: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.limitLoad && limitField == '0) |=> (limitSteps == MAX_STEPS));

  a_r2_single_steps: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(stepCount) |-> (stepCount == '0 || stepCount == $past(stepCount) + STEP_W'(1)));

  a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rstN)
    wrapEvent |=> (stepCount == '0));

endmodule

// File: rtl/it_ctrl.sv
module it_ctrl
  import interval_timer_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int STEP_W  = 22,
  parameter int STEP_LSB = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [2:0]        regOfs,
  input  logic              wrapEvent,
  input  logic [STEP_W-1:0] stepCount,
  input  logic [STEP_W-1:0] limitSteps,
  output ctlStrobes_t       ctl,
  output logic [DATA_W-1:0] rdData,
  output logic              irqLevel
);

  logic reachedFlag;
  logic rdLimit;

  // Decode
  always_comb begin
    ctl.cntClear  = regWr && (regOfs == OFS_LIMIT_RESTART);
    ctl.limitLoad = regWr && (regOfs == OFS_LIMIT_RESTART || regOfs == OFS_LIMIT_KEEP);
    rdLimit       = regRd && (regOfs == OFS_LIMIT_RESTART);
  end

  // Sticky reached flag; an expiry beats an acknowledge on the same edge.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reachedFlag <= 1'b0;
    end else if (wrapEvent) begin
      reachedFlag <= 1'b1;
    end else if (rdLimit) begin
      reachedFlag <= 1'b0;
    end
  end

  // Interrupt level; also dropped by a restarting limit write.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqLevel <= 1'b0;
    end else if (wrapEvent) begin
      irqLevel <= 1'b1;
    end else if (rdLimit || ctl.cntClear) begin
      irqLevel <= 1'b0;
    end
  end

  // Read mux
  always_comb begin
    case (regOfs)
      OFS_LIMIT_RESTART: rdData = {1'b0, limitSteps, {STEP_LSB{1'b0}}};
      OFS_COUNT:         rdData = {reachedFlag, stepCount, {STEP_LSB{1'b0}}};
      default:           rdData = '0;
    endcase
  end

  a_r3_expiry_flags: assert property (@(posedge clk) disable iff (!rstN)
    wrapEvent |=> (reachedFlag && irqLevel));

  a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (rdLimit && !wrapEvent) |=> (!reachedFlag && !irqLevel));

  a_r3_irq_only_on_expiry: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqLevel) |-> $past(wrapEvent));

  a_r5_restart_drops_irq: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.cntClear && !wrapEvent) |=> !irqLevel);

endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import interval_timer_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 5,
  parameter int STEP_LSB = 9,
  parameter int TICK_DIV = 125
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irqOut
);

  localparam int STEP_W = DATA_W - 1 - STEP_LSB;

  ctlStrobes_t       ctl;
  logic              wrapEvent;
  logic [STEP_W-1:0] stepCount;
  logic [STEP_W-1:0] limitSteps;
  logic              unusedBits;

  assign unusedBits = ^{regAddr[1:0], regWdata[DATA_W-1], regWdata[STEP_LSB-1:0]};

  it_ctrl #(
    .DATA_W  (DATA_W),
    .STEP_W  (STEP_W),
    .STEP_LSB(STEP_LSB)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWr     (regWr),
    .regRd     (regRd),
    .regOfs    (regAddr[4:2]),
    .wrapEvent (wrapEvent),
    .stepCount (stepCount),
    .limitSteps(limitSteps),
    .ctl       (ctl),
    .rdData    (regRdata),
    .irqLevel  (irqOut)
  );

  it_datapath #(
    .STEP_W  (STEP_W),
    .TICK_DIV(TICK_DIV)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .limitField(regWdata[DATA_W-2:STEP_LSB]),
    .stepCount (stepCount),
    .limitSteps(limitSteps),
    .wrapEvent (wrapEvent)
  );

endmodule

// File: tb/sim_interval_timer.sv
`timescale 1ns/1ps
module sim_interval_timer;

  localparam int D = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        irqOut;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  interval_timer #(.TICK_DIV(D)) u0 (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic peek(input logic [4:0] addr, output logic [31:0] v);
    regAddr = addr;
    #1 v = regRdata;
  endtask

  task automatic wr(input int ofs, input logic [31:0] d);
    regWr = 1'b1; regAddr = 5'(ofs * 4); regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd0(output logic [31:0] v);
    regRd = 1'b1; regAddr = 5'd0;
    #1 v = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  // Acknowledge and restart in one cycle: afterwards count=0, reached=0.
  task automatic loadReset(input logic [31:0] d);
    regWr = 1'b1; regRd = 1'b1; regAddr = 5'd0; regWdata = d;
    @(negedge clk);
    regWr = 1'b0; regRd = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] e;
    tick(3);
    rstN = 1'b1;
    // R1 reset state
    peek(5'd4, v); chk("R1 count", v, 32'h0);
    peek(5'd0, v); chk("R1 limit", v, 32'h7FFF_FE00);
    chk("R1 irq", {31'b0, irqOut}, 32'h0);

    // R2 R3 R8 sweep of small limits
    for (int L = 1; L <= 6; L++) begin
      loadReset(32'(L) << 9);
      for (int n = 0; n <= 2 * L * D + 2; n++) begin
        peek(5'd4, v);
        e = {(n >= L * D), 31'((((n / D) % L)) << 9)};
        chk("R2 R3 R8 count word", v, e);
        chk("R3 irq", {31'b0, irqOut}, {31'b0, (n >= L * D)});
        tick(1);
      end
    end

    // R4 acknowledge
    loadReset(32'h200);
    tick(4);
    peek(5'd4, v); chk("R4 reached before ack", v, 32'h8000_0000);
    rd0(v); chk("R4 limit read", v, 32'h200);
    peek(5'd4, v); chk("R4 reached cleared", v, 32'h0);
    chk("R4 irq cleared", {31'b0, irqOut}, 32'h0);
    tick(1);
    chk("R4 irq after next expiry", {31'b0, irqOut}, 32'h1);
    tick(2);
    rd0(v);
    peek(5'd4, v); chk("R4 expiry wins over ack", v, 32'h8000_0000);
    chk("R4 irq expiry wins", {31'b0, irqOut}, 32'h1);

    // R5 restarting write keeps reached, drops irq
    loadReset(32'h200);
    tick(4);
    wr(0, 32'(100) << 9);
    peek(5'd4, v); chk("R5 count restart, reached kept", v, 32'h8000_0000);
    chk("R5 irq dropped", {31'b0, irqOut}, 32'h0);
    tick(D);
    peek(5'd4, v); chk("R5 prescaler restarted", v, 32'h8000_0200);
    peek(5'd0, v); chk("R5 limit stored", v, 32'h0000_C800);

    // R6 limit load without restart
    loadReset(32'(10) << 9);
    tick(7);
    wr(2, 32'(20) << 9);
    peek(5'd4, v); chk("R6 count kept", v, 32'h400);
    peek(5'd0, v); chk("R6 limit", v, 32'h2800);
    tick(1);
    peek(5'd4, v); chk("R6 phase kept", v, 32'h600);
    wr(2, 32'(2) << 9);
    tick(2);
    peek(5'd4, v); chk("R3 R6 limit below count wraps", v, 32'h8000_0000);
    chk("R3 irq", {31'b0, irqOut}, 32'h1);
    tick(D);
    peek(5'd4, v); chk("R6 next step", v, 32'h8000_0200);
    tick(D);
    peek(5'd4, v); chk("R6 new period", v, 32'h8000_0000);

    // R7 zero limit selects maximum
    loadReset(32'h0);
    peek(5'd0, v); chk("R7 zero via offset 0", v, 32'h7FFF_FE00);
    wr(0, 32'h80000A00);
    peek(5'd0, v); chk("R5 masking", v, 32'h0000_0A00);
    wr(2, 32'h0000_01FF);
    peek(5'd0, v); chk("R7 zero via offset 2", v, 32'h7FFF_FE00);
    wr(0, 32'hFFFF_FFFF);
    peek(5'd0, v); chk("R5 full mask", v, 32'h7FFF_FE00);
    wr(2, 32'h0000_05FF);
    peek(5'd0, v); chk("R6 masking", v, 32'h0000_0400);

    // R9 unused offsets
    loadReset(32'(50) << 9);
    wr(1, 32'h600); wr(3, 32'h600); wr(4, 32'h600);
    wr(5, 32'h600); wr(6, 32'h600); wr(7, 32'h600);
    peek(5'd4, v); chk("R9 count not restarted", v, 32'h400);
    peek(5'd0, v); chk("R9 limit unchanged", v, 32'h6400);
    chk("R9 irq", {31'b0, irqOut}, 32'h0);
    for (int o = 2; o <= 7; o++) begin
      peek({3'(o), 2'b11}, v); chk("R9 unused offset reads zero", v, 32'h0);
    end
    peek(5'b000_11, v); chk("R9 low address bits ignored", v, 32'h6400);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule